// File: doc/BRIEF.md
# Slow-Clock Power-Down Sequencer with Debounced Wake Sources

This block sits in the always-on domain of a chip and runs from the 32.768 kHz slow clock. A host on a simple register bus arms a power-down by writing a keyed command. The block then drives an output that removes the main power domain. While that output is asserted, the block watches up to sixteen external wake pins and two alarm pulses from the always-on timers. Each pin has its own enable and its own active level. A pin passes a two-stage synchronizer and then a debounce counter whose length comes from a fixed table. The first qualifying event releases the power-down output and records its cause in a status word that clears when it is read.

Software picks the debounce length and the alarm enables in a mode register, and the per-pin enables and levels in a pin configuration register. After power returns, software reads the status word once to learn why the chip woke. If the status word reads all zero, the chip came up from a plain power-on.

Top module: `shutdown_ctl`

## Requirements
- R1: After reset, `pwr_off_o` is 0 and all four registers (byte offsets 0x0, 0x4, 0x8, 0xC) read as zero.
- R2: A write to offset 0x0 asserts `pwr_off_o` at the next clock edge, but only when bit 0 is 1 and bits 31:24 equal 0xA5. Any other value written there is ignored.
- R3: The mode register at offset 0x4 keeps its debounce code in bits 26:24, the timer-alarm wake enable in bit 17 and the counter-alarm wake enable in bit 16. All its other bits read 0. The pin configuration register at offset 0xC reads back all 32 bits.
- R4: The debounce codes 0 to 5 select 0, 3, 32, 512, 4096 and 32768 cycles. `pwr_off_o` falls on the clock edge numbered max(N,1)+2, counted from the pin reaching its active level (two synchronizer stages plus N stable samples).
- R5: The debounce codes 6 and 7 behave exactly like code 5.
- R6: Bit i of offset 0xC enables pin i. Bit 16+i sets that pin's active level (1 = high, 0 = low). A disabled pin never causes a wake.
- R7: If an enabled pin leaves its active level for even one sample, its debounce count starts again from zero.
- R8: While powered down, a timer-alarm pulse with bit 17 set, or a counter-alarm pulse with bit 16 set, releases `pwr_off_o` at the next edge. An alarm whose enable bit is clear is ignored.
- R9: The status register at offset 0x8 flags pin i in bit 16+i, a timer-alarm wake in bit 5 and a counter-alarm wake in bit 4. A read returns the value and clears it, so the next read returns zero.
- R10: The status register changes only on a wake that ends a power-down, and only when it holds zero (or is being read in that cycle). An unread cause is kept through later wakes.
- R11: Once `pwr_off_o` is asserted, it stays asserted until a valid wake. Further keyed writes have no effect on it or on the debounce timing.
- R12: When zero has been written to offsets 0x4 and 0xC, no pin activity and no alarm pulse releases a power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears it) |
| addr | input | 4 | Byte address; only word-aligned offsets decode |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| wake_pin_i | input | 16 | Asynchronous wake pins |
| rtc_alarm_i | input | 1 | Timer alarm pulse, slow-clock synchronous |
| rtt_alarm_i | input | 1 | Counter alarm pulse, slow-clock synchronous |
| pwr_off_o | output | 1 | Main-domain power-down request |

## Verification
The checker watches four things on every cycle. A rising power-down always follows a keyed write to offset 0x0. The output holds while no wake event exists. An enabled timer alarm ends a power-down in one edge. The status word stays put unless it is read or a wake lands on an empty word. The debounce table lengths, the restart after a one-sample glitch, the per-pin levels and the exact wake latency are shown only by the bench, which sweeps all eight debounce codes and counts edges until release. The same goes for the retention of an unread cause across a second wake.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_PCFG = 2'd3
  } reg_sel_e;

  localparam logic [7:0] CMD_KEY = 8'hA5;

  // Debounce length table; reserved codes fall back to the longest entry.
  function automatic logic [15:0] dbc_len(input logic [2:0] code);
    case (code)
      3'd0:    dbc_len = 16'd0;
      3'd1:    dbc_len = 16'd3;
      3'd2:    dbc_len = 16'd32;
      3'd3:    dbc_len = 16'd512;
      3'd4:    dbc_len = 16'd4096;
      default: dbc_len = 16'd32768;
    endcase
  endfunction

endpackage

// File: rtl/shdn_sync.sv
module shdn_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= async_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_o = stg2_q;
endmodule

// File: rtl/shdn_debounce.sv
module shdn_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             level,
  input  logic             pol,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic             active;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active = arm && (level == pol);
    if (!active)
      cnt_d = '0;
    else if (&cnt_q)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
    cnt_en = active || (|cnt_q);
    hit    = active && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/shutdown_ctl.sv
module shutdown_ctl
  import shdn_pkg::*;
#(
  parameter int NWAKE = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [15:0] wake_pin_i,
  input  logic        rtc_alarm_i,
  input  logic        rtt_alarm_i,
  output logic        pwr_off_o
);
  localparam int POL_LSB = 16;

  reg_sel_e         sel;
  logic             acc_ok, wr_cmd, wr_mode, wr_pcfg, rd_stat, key_ok;
  logic             shdn_q, shdn_d;
  logic [2:0]       dbc_code_q;
  logic             rtc_en_q, rtt_en_q;
  logic [31:0]      pcfg_q;
  logic [31:0]      status_q, status_d, cause;
  logic [NWAKE-1:0] pin_sync, pin_hit;
  logic [CNT_W-1:0] limit;
  logic             rtc_hit, rtt_hit, wake_evt;

  always_comb begin
    sel     = reg_sel_e'(addr[3:2]);
    acc_ok  = (addr[1:0] == 2'b00);
    wr_cmd  = wr_en && acc_ok && (sel == SEL_CMD);
    wr_mode = wr_en && acc_ok && (sel == SEL_MODE);
    wr_pcfg = wr_en && acc_ok && (sel == SEL_PCFG);
    rd_stat = rd_en && acc_ok && (sel == SEL_STAT);
    key_ok  = (wdata[31:24] == CMD_KEY) && wdata[0];
    limit   = CNT_W'(dbc_len(dbc_code_q));
  end

  shdn_sync #(.W(NWAKE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (wake_pin_i[NWAKE-1:0]),
    .sync_o  (pin_sync)
  );

  for (genvar i = 0; i < NWAKE; i++) begin : g_ch
    shdn_debounce #(.CNT_W(CNT_W)) u_dbc (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (shdn_q && pcfg_q[i]),
      .level (pin_sync[i]),
      .pol   (pcfg_q[POL_LSB+i]),
      .limit (limit),
      .hit   (pin_hit[i])
    );
  end

  always_comb begin
    rtc_hit  = shdn_q && rtc_en_q && rtc_alarm_i;
    rtt_hit  = shdn_q && rtt_en_q && rtt_alarm_i;
    wake_evt = shdn_q && ((|pin_hit) || rtc_hit || rtt_hit);

    cause = '0;
    cause[POL_LSB +: NWAKE] = pin_hit;
    cause[5] = rtc_hit;
    cause[4] = rtt_hit;

    if (shdn_q)
      shdn_d = !wake_evt;
    else
      shdn_d = wr_cmd && key_ok;

    if (rd_stat)
      status_d = wake_evt ? cause : '0;
    else if (wake_evt && (status_q == '0))
      status_d = cause;
    else
      status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_q   <= 1'b0;
      status_q <= '0;
    end else begin
      shdn_q   <= shdn_d;
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbc_code_q <= '0;
      rtc_en_q   <= 1'b0;
      rtt_en_q   <= 1'b0;
    end else if (wr_mode) begin
      dbc_code_q <= wdata[26:24];
      rtc_en_q   <= wdata[17];
      rtt_en_q   <= wdata[16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcfg_q <= '0;
    else if (wr_pcfg)
      pcfg_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd_en && acc_ok) begin
      case (sel)
        SEL_MODE: rdata = {5'b0, dbc_code_q, 6'b0, rtc_en_q, rtt_en_q, 16'b0};
        SEL_STAT: rdata = status_q;
        SEL_PCFG: rdata = pcfg_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign pwr_off_o = shdn_q;
endmodule

// File: rtl/shutdown_ctl_chk.sv
module shutdown_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [7:0]  wkey,
  input logic        wgo,
  input logic        rtc_alarm_i,
  input logic        shdn_q,
  input logic        wake_evt,
  input logic        rtc_en_q,
  input logic [31:0] status_q
);
  logic stat_rd;
  assign stat_rd = rd_en && (addr == 4'h8);

  // R2: power-down only rises after a keyed command write
  a_r2_keyed_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_q) |-> $past(wr_en && addr == 4'h0 && wkey == 8'hA5 && wgo));

  // R11: no release without a wake event
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_q && !wake_evt) |=> shdn_q);

  // R8: enabled timer alarm ends power-down on the next edge
  a_r8_rtc_release: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_q && rtc_en_q && rtc_alarm_i) |=> (!shdn_q && status_q != 32'h0));

  // R10: a pending cause survives until read
  a_r10_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != 32'h0 && !stat_rd) |=> $stable(status_q));

  // R10: an empty status stays empty without a wake
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 32'h0 && !wake_evt) |=> status_q == 32'h0);

  // R9: reading clears when no new wake coincides
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wake_evt) |=> status_q == 32'h0);
endmodule

bind shutdown_ctl shutdown_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wkey        (wdata[31:24]),
  .wgo         (wdata[0]),
  .rtc_alarm_i (rtc_alarm_i),
  .shdn_q      (shdn_q),
  .wake_evt    (wake_evt),
  .rtc_en_q    (rtc_en_q),
  .status_q    (status_q)
);

// File: tb/shutdown_ctl_bench.sv
module shutdown_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [15:0] wake_pin_i;
  logic        rtc_alarm_i, rtt_alarm_i;
  logic        pwr_off_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  shutdown_ctl u_shutdown_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wake_pin_i(wake_pin_i),
    .rtc_alarm_i(rtc_alarm_i), .rtt_alarm_i(rtt_alarm_i), .pwr_off_o(pwr_off_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one pin, then count edges until power-down releases
  task automatic drive_and_count(input int idx, input logic val, output int cnt);
    @(negedge clk); wake_pin_i[idx] = val;
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
    end while (pwr_off_o && cnt < 40000);
  endtask

  task automatic pulse_alarm(input bit rtc);
    @(negedge clk);
    if (rtc) rtc_alarm_i = 1'b1; else rtt_alarm_i = 1'b1;
    @(negedge clk);
    rtc_alarm_i = 1'b0; rtt_alarm_i = 1'b0;
  endtask

  function automatic int tbl(input int code);
    case (code)
      0: tbl = 0; 1: tbl = 3; 2: tbl = 32; 3: tbl = 512; 4: tbl = 4096;
      default: tbl = 32768;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cnt, exp;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    wake_pin_i = '0; rtc_alarm_i = 0; rtt_alarm_i = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check(pwr_off_o == 1'b0, "R1 pwr_off", pwr_off_o, 0);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a*4), d);
      check(d == 32'h0, "R1 register reset", d, 0);
    end

    // R3 register fields
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d);
    check(d == 32'h0703_0000, "R3 mode readback", d, 32'h0703_0000);
    wr(4'hC, 32'hA5A5_5A5A); rd(4'hC, d);
    check(d == 32'hA5A5_5A5A, "R3 pin cfg readback", d, 32'hA5A5_5A5A);

    // R2 key checking
    wr(4'hC, 32'h0001_0001); wr(4'h4, 32'h0);
    wr(4'h0, 32'h5A00_0001); idle(1);
    check(pwr_off_o == 1'b0, "R2 wrong key ignored", pwr_off_o, 0);
    wr(4'h0, 32'hA500_0000); idle(1);
    check(pwr_off_o == 1'b0, "R2 bit0 clear ignored", pwr_off_o, 0);

    // R4/R5 debounce sweep on pin 0, active high; R9 status and clear
    for (int code = 0; code < 8; code++) begin
      wr(4'h4, 32'(code) << 24);
      wake_pin_i[0] = 1'b0; idle(3);
      wr(4'h0, 32'hA500_0001);
      check(pwr_off_o == 1'b1, "R2 keyed entry", pwr_off_o, 1);
      if (code == 2) begin
        wr(4'h0, 32'hA500_0001);
        check(pwr_off_o == 1'b1, "R11 repeat key", pwr_off_o, 1);
      end
      drive_and_count(0, 1'b1, cnt);
      exp = ((tbl(code) > 1) ? tbl(code) : 1) + 2;
      check(cnt == exp, (code >= 6) ? "R5 reserved code latency" : "R4 debounce latency", cnt, exp);
      rd(4'h8, d);
      check(d == 32'h0001_0000, "R9 pin cause", d, 32'h0001_0000);
      rd(4'h8, d);
      check(d == 32'h0, "R9 cleared on read", d, 0);
      wake_pin_i[0] = 1'b0;
    end

    // R6 polarity and disabled pin: pin5 active low enabled, pin9 disabled
    wake_pin_i[5] = 1'b1;
    wr(4'hC, 32'h0000_0020); wr(4'h4, 32'h0100_0000); idle(3);
    wr(4'h0, 32'hA500_0001);
    wake_pin_i[9] = 1'b1; idle(12); wake_pin_i[9] = 1'b0; idle(4);
    check(pwr_off_o == 1'b1, "R6 disabled pin no wake", pwr_off_o, 1);
    drive_and_count(5, 1'b0, cnt);
    check(cnt == 5, "R6 active-low latency", cnt, 5);
    rd(4'h8, d);
    check(d == 32'h0020_0000, "R6 cause bit 21", d, 32'h0020_0000);
    wake_pin_i[5] = 1'b1;

    // R7 glitch restart with code 2
    wr(4'hC, 32'h0001_0001); wr(4'h4, 32'h0200_0000); idle(3);
    wr(4'h0, 32'hA500_0001);
    @(negedge clk); wake_pin_i[0] = 1'b1; idle(20);
    wake_pin_i[0] = 1'b0; idle(1);
    check(pwr_off_o == 1'b1, "R7 still down before glitch end", pwr_off_o, 1);
    drive_and_count(0, 1'b1, cnt);
    check(cnt == 34, "R7 count restarted", cnt, 34);
    rd(4'h8, d); wake_pin_i[0] = 1'b0;

    // R8 alarms: disabled ignored, enabled wake next edge
    wr(4'hC, 32'h0); wr(4'h4, 32'h0); idle(3);
    wr(4'h0, 32'hA500_0001);
    pulse_alarm(1); pulse_alarm(0); idle(2);
    check(pwr_off_o == 1'b1, "R8 disabled alarms ignored", pwr_off_o, 1);
    wr(4'h4, 32'h0002_0000);
    pulse_alarm(1);
    check(pwr_off_o == 1'b0, "R8 timer alarm wake", pwr_off_o, 0);
    rd(4'h8, d);
    check(d == 32'h20, "R8 timer alarm status bit 5", d, 32'h20);
    wr(4'h4, 32'h0001_0000); wr(4'h0, 32'hA500_0001);
    pulse_alarm(0);
    check(pwr_off_o == 1'b0, "R8 counter alarm wake", pwr_off_o, 0);
    rd(4'h8, d);
    check(d == 32'h10, "R8 counter alarm status bit 4", d, 32'h10);

    // R10 pending cause kept across a second wake
    wr(4'hC, 32'h0001_0001); wr(4'h4, 32'h0002_0000); idle(3);
    wr(4'h0, 32'hA500_0001);
    drive_and_count(0, 1'b1, cnt);
    wake_pin_i[0] = 1'b0; idle(3);
    wr(4'h0, 32'hA500_0001);
    pulse_alarm(1);
    check(pwr_off_o == 1'b0, "R10 second wake", pwr_off_o, 0);
    rd(4'h8, d);
    check(d == 32'h0001_0000, "R10 first cause kept", d, 32'h0001_0000);
    rd(4'h8, d);
    check(d == 32'h0, "R10 cleared after read", d, 0);

    // R12 all sources disabled by zero writes
    wr(4'h4, 32'h0); wr(4'hC, 32'h0); idle(2);
    wr(4'h0, 32'hA500_0001);
    wake_pin_i = 16'hFFFF; idle(8); wake_pin_i = 16'h0000; idle(8);
    pulse_alarm(1); pulse_alarm(0); idle(40);
    check(pwr_off_o == 1'b1, "R12 no wake source", pwr_off_o, 1);
    rd(4'h8, d);
    check(d == 32'h0, "R12 status untouched", d, 0);

    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    check(pwr_off_o == 1'b0, "R1 reset releases", pwr_off_o, 0);

    finish_run();
  end
endmodule